// File: doc/BRIEF.md
# PAM4 Two-Symbol Branch Metric Unit

This unit feeds the first layer of a four-level sequence detector. The channel target is the two-tap response 1 + αD. The unit takes two consecutive equalized samples and a programmable tap α. It returns the squared Euclidean distance, summed over both samples, for each of the 64 paths that run from a start state through a middle state to an end state. Each state is one PAM4 level.

The distance is expanded into a few shared term vectors that every path reuses. Only five variable multipliers remain: y0², y1², y0·α, y1·α and α². Every scaling by a level value or by a level product uses shifts and adds. The 64 metrics are registered once, so one sample pair is accepted on every clock.

Top module: `pam4_bmu2`

## Requirements
- R1: Symbol index k (2 bits) stands for level 2k−3, so indices 0..3 map to −3, −1, +1, +3. One level unit equals 16 sample LSBs. The metric for path (start s, middle m, end e) sits at `metric_o[(16*s+4*m+e)*16 +: 16]`.
- R2: With alpha_i = a, the value of α is a/256. Define d0 = 256·y0 − 4096·L(m) − 16·a·L(s) and d1 = 256·y1 − 4096·L(e) − 16·a·L(m). The metric is floor((d0² + d1²)/65536). Here y0 is the earlier sample.
- R3: A metric whose value exceeds 65535 is output as 65535.
- R4: Metrics for a pair presented with in_valid_i high appear on the next clock edge, and out_valid_o is high for exactly that cycle.
- R5: In a cycle with in_valid_i low, metric_o keeps its previous contents and out_valid_o goes low on the next edge.
- R6: While rst_ni is low, out_valid_o is 0 and every metric is 0.
- R7: With α = 0, every metric is independent of the start state.
- R8: Negating both samples while mirroring every index (k → 3−k) leaves each metric unchanged.
- R9: Pairs presented on consecutive cycles each yield their own correct metrics, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample pair and alpha are valid |
| y0_i | input | 8 | Earlier equalized sample, signed |
| y1_i | input | 8 | Later equalized sample, signed |
| alpha_i | input | 8 | Post-cursor tap, unsigned fraction of 256 |
| out_valid_o | output | 1 | metric_o was updated on the last edge |
| metric_o | output | 1024 | 64 saturating 16-bit path metrics |

## Verification
A wrong shared term shows up as a group of metrics that are wrong in a pattern. A bad level-dependent term corrupts every path that shares that middle or end index. A bad α-dependent term corrupts a whole start-state group. Either fault is visible on the cycle right after the pair is accepted. For this reason the bench compares all 64 outputs on every clock. It also checks mirrored and α = 0 pairs, which expose sign and indexing faults that random data might hide. Hold and valid faults appear within one idle cycle.

// File: rtl/pam4_bmu_pkg.sv
package pam4_bmu_pkg;
  localparam int SAMPLE_W  = 8;
  localparam int ALPHA_W   = 8;
  localparam int LVL_SHIFT = 4;   // LSBs per level unit = 2**LVL_SHIFT
  localparam int METRIC_W  = 16;
  localparam int NUM_LVL   = 4;
  localparam int TERM_W    = 64;

  typedef logic signed [TERM_W-1:0] term_t;

  // x * (2k-3) with shifts and adds
  function automatic term_t lvl_mul(term_t x, logic [1:0] k);
    case (k)
      2'd0:    return -((x <<< 1) + x);
      2'd1:    return -x;
      2'd2:    return x;
      default: return (x <<< 1) + x;
    endcase
  endfunction

  // x * (2k-3)^2, i.e. x*9 or x*1
  function automatic term_t lvl_sq_mul(term_t x, logic [1:0] k);
    if (k == 2'd0 || k == 2'd3) return (x <<< 3) + x;
    return x;
  endfunction
endpackage

// File: rtl/bmu_sample_terms.sv
module bmu_sample_terms
  import pam4_bmu_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int AW = ALPHA_W,
  parameter int LS = LVL_SHIFT
) (
  input  logic signed [SW-1:0] y_i,
  input  logic        [AW-1:0] alpha_i,
  output term_t                a_term_o [NUM_LVL],  // per current level
  output term_t                c_term_o [NUM_LVL]   // per previous level
);
  localparam int SQ_W = 2 * SW;
  localparam int YA_W = SW + AW + 1;

  logic signed [SQ_W-1:0] y_sq;
  logic signed [YA_W-1:0] y_a;

  assign y_sq = SQ_W'(y_i) * SQ_W'(y_i);
  assign y_a  = YA_W'(y_i) * $signed(YA_W'({1'b0, alpha_i}));

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    assign a_term_o[k] = (term_t'(y_sq) <<< (2 * AW))
                       - (lvl_mul(term_t'(y_i), 2'(k)) <<< (1 + 2 * AW + LS))
                       + (lvl_sq_mul(term_t'(1), 2'(k)) <<< (2 * (LS + AW)));
    assign c_term_o[k] = -(lvl_mul(term_t'(y_a), 2'(k)) <<< (1 + AW + LS));
  end
endmodule

// File: rtl/bmu_shared_terms.sv
module bmu_shared_terms
  import pam4_bmu_pkg::*;
#(
  parameter int AW = ALPHA_W,
  parameter int LS = LVL_SHIFT
) (
  input  logic [AW-1:0] alpha_i,
  output term_t         b_term_o [NUM_LVL],           // alpha^2 * Lp^2
  output term_t         d_term_o [NUM_LVL][NUM_LVL]   // alpha * Lp * Ls
);
  localparam int ASQ_W = 2 * AW;

  logic [ASQ_W-1:0] a_sq;
  term_t            a_w;

  assign a_sq = ASQ_W'(alpha_i) * ASQ_W'(alpha_i);
  assign a_w  = term_t'({1'b0, alpha_i});

  for (genvar j = 0; j < NUM_LVL; j++) begin : g_prev
    assign b_term_o[j] = lvl_sq_mul(term_t'({1'b0, a_sq}), 2'(j)) <<< (2 * LS);
    for (genvar k = 0; k < NUM_LVL; k++) begin : g_cur
      assign d_term_o[j][k] =
        lvl_mul(lvl_mul(a_w, 2'(j)), 2'(k)) <<< (1 + 2 * LS + AW);
    end
  end
endmodule

// File: rtl/pam4_bmu2.sv
module pam4_bmu2
  import pam4_bmu_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int AW = ALPHA_W,
  parameter int LS = LVL_SHIFT,
  parameter int MW = METRIC_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic signed [SW-1:0]       y0_i,
  input  logic signed [SW-1:0]       y1_i,
  input  logic        [AW-1:0]       alpha_i,
  output logic                       out_valid_o,
  output logic [NUM_LVL**3*MW-1:0]   metric_o
);
  localparam int NP = NUM_LVL ** 3;
  localparam term_t SAT = term_t'((64'd1 << MW) - 1);

  term_t a0 [NUM_LVL];
  term_t c0 [NUM_LVL];
  term_t a1 [NUM_LVL];
  term_t c1 [NUM_LVL];
  term_t b  [NUM_LVL];
  term_t d  [NUM_LVL][NUM_LVL];

  bmu_sample_terms #(.SW(SW), .AW(AW), .LS(LS)) u_first (
    .y_i(y0_i), .alpha_i(alpha_i), .a_term_o(a0), .c_term_o(c0));
  bmu_sample_terms #(.SW(SW), .AW(AW), .LS(LS)) u_second (
    .y_i(y1_i), .alpha_i(alpha_i), .a_term_o(a1), .c_term_o(c1));
  bmu_shared_terms #(.AW(AW), .LS(LS)) u_shared (
    .alpha_i(alpha_i), .b_term_o(b), .d_term_o(d));

  logic [NP*MW-1:0] metric_d;

  for (genvar s = 0; s < NUM_LVL; s++) begin : g_s
    for (genvar m = 0; m < NUM_LVL; m++) begin : g_m
      for (genvar e = 0; e < NUM_LVL; e++) begin : g_e
        term_t sq0, sq1, tot;
        assign sq0 = a0[m] + b[s] + c0[s] + d[s][m];
        assign sq1 = a1[e] + b[m] + c1[m] + d[m][e];
        assign tot = (sq0 + sq1) >>> (2 * AW);
        assign metric_d[(16*s+4*m+e)*MW +: MW] =
          (tot > SAT) ? {MW{1'b1}} : tot[MW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      metric_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) metric_o <= metric_d;
    end
  end

  a_r4_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o) else $error("R4 out_valid missing");
  a_r5_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o) else $error("R5 out_valid stuck");
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(metric_o)) else $error("R5 metrics changed");

  // R8: shared terms must be mirror symmetric
  for (genvar j = 0; j < NUM_LVL; j++) begin : g_chk_j
    a_r8_mirror_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b[j] == b[NUM_LVL-1-j]) else $error("R8 b asymmetric");
    for (genvar k = 0; k < NUM_LVL; k++) begin : g_chk_k
      a_r8_mirror_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
        d[j][k] == d[NUM_LVL-1-j][NUM_LVL-1-k]) else $error("R8 d asymmetric");
    end
  end
endmodule

// File: tb/pam4_bmu2_test.sv
module pam4_bmu2_test;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               in_valid_i = 1'b0;
  logic signed [7:0]  y0_i = '0;
  logic signed [7:0]  y1_i = '0;
  logic        [7:0]  alpha_i = '0;
  logic               out_valid_o;
  logic [1023:0]      metric_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] exp_m [64];
  bit          exp_v = 1'b0;
  logic [15:0] snap [64];

  always #2ns clk = ~clk;

  pam4_bmu2 uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .y0_i(y0_i), .y1_i(y1_i), .alpha_i(alpha_i),
    .out_valid_o(out_valid_o), .metric_o(metric_o));

  function automatic longint lv(int k);
    return longint'(2 * k - 3);
  endfunction

  function automatic logic [15:0] ref_m(int y0, int y1, int a, int s, int m, int e);
    longint d0, d1, t;
    d0 = 256 * longint'(y0) - 4096 * lv(m) - 16 * longint'(a) * lv(s);
    d1 = 256 * longint'(y1) - 4096 * lv(e) - 16 * longint'(a) * lv(m);
    t  = (d0 * d0 + d1 * d1) >>> 16;
    if (t > 65535) t = 65535;
    return t[15:0];
  endfunction

  function automatic logic [15:0] get_m(int idx);
    return metric_o[idx*16 +: 16];
  endfunction

  task automatic check_outputs(string req);
    int bad;
    tests++;
    if (out_valid_o !== exp_v) begin
      fails++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", req, out_valid_o, exp_v);
    end
    tests++;
    bad = -1;
    for (int i = 0; i < 64; i++)
      if (bad < 0 && get_m(i) !== exp_m[i]) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s metric[%0d] actual=%0d expected=%0d", req, bad, get_m(bad), exp_m[bad]);
    end
  endtask

  task automatic step(int y0, int y1, int a, bit v, string req);
    @(negedge clk);
    y0_i = 8'(y0); y1_i = 8'(y1); alpha_i = 8'(a); in_valid_i = v;
    @(posedge clk);
    if (v)
      for (int i = 0; i < 64; i++) exp_m[i] = ref_m(y0, y1, a, i / 16, (i / 4) % 4, i % 4);
    exp_v = v;
    #1ns;
    check_outputs(req);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int bad;
    for (int i = 0; i < 64; i++) exp_m[i] = '0;
    repeat (3) @(negedge clk);
    check_outputs("R6 reset");
    rst_ni = 1'b1;

    // R1: samples on levels -1 then +3, alpha 0 -> paths (*,1,3) are zero
    step(-16, 48, 0, 1'b1, "R1 level map");
    tests++;
    if (get_m(16*2 + 4*1 + 3) !== 16'd0 || get_m(4*1 + 2) !== 16'd1024) begin
      fails++;
      $display("FAIL R1 metric actual=%0d/%0d expected=0/1024",
               get_m(16*2 + 4*1 + 3), get_m(4*1 + 2));
    end

    // R7: alpha 0, start state irrelevant
    step(37, -91, 0, 1'b1, "R7 alpha zero");
    tests++;
    bad = -1;
    for (int i = 16; i < 64; i++) if (bad < 0 && get_m(i) !== get_m(i % 16)) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL R7 metric[%0d] actual=%0d expected=%0d", bad, get_m(bad), get_m(bad % 16));
    end

    // R3: saturation corner
    step(-128, -128, 255, 1'b1, "R3 saturation");
    tests++;
    if (get_m(63) !== 16'hFFFF) begin
      fails++;
      $display("FAIL R3 metric[63] actual=%0d expected=65535", get_m(63));
    end
    step(127, 127, 255, 1'b1, "R3 saturation high");

    // R8: mirror symmetry
    for (int r = 0; r < 4; r++) begin
      int y0, y1, a;
      y0 = $urandom_range(254) - 127;
      y1 = $urandom_range(254) - 127;
      a  = $urandom_range(255);
      step(y0, y1, a, 1'b1, "R8 base");
      for (int i = 0; i < 64; i++) snap[i] = get_m(i);
      step(-y0, -y1, a, 1'b1, "R8 mirrored");
      tests++;
      bad = -1;
      for (int i = 0; i < 64; i++) if (bad < 0 && get_m(63 - i) !== snap[i]) bad = i;
      if (bad >= 0) begin
        fails++;
        $display("FAIL R8 metric[%0d] actual=%0d expected=%0d", 63 - bad, get_m(63 - bad), snap[bad]);
      end
    end

    // R5: idle cycles with changing inputs hold metrics
    step(100, -100, 200, 1'b0, "R5 hold");
    step(-5, 7, 9, 1'b0, "R5 hold");

    // R9/R2: back-to-back pairs
    for (int c = 0; c < 100; c++)
      step($urandom_range(255) - 128, $urandom_range(255) - 128, $urandom_range(255), 1'b1, "R9 back-to-back");

    // R2/R4/R5: random valid pattern
    for (int c = 0; c < 400; c++)
      step($urandom_range(255) - 128, $urandom_range(255) - 128, $urandom_range(255),
           ($urandom_range(9) < 7), "R2 random");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule